// File: doc/BRIEF.md
# Variable Refresh Vertical Line Counter

This block counts display lines for the vertical side of a timing generator whose frame length may vary from frame to frame. Each pulse on the line strobe advances the count by one line. A frame runs from line 0 up to a programmed last line. An external trigger may cut the frame short once a programmed earliest line has been reached. A frame-start pulse marks every return to line 0.

Frames longer than the counter can express are built by a freeze-and-extend step. When the counter reaches a programmed stop line, it stays there while a second counter runs out a programmed number of extra lines. The main counter then carries on. A mid total can stand in for the maximum for a set number of frames, and after those frames the maximum applies again. All configuration is captured into shadow registers only when a frame ends, and on the first cycle after reset.

Top module: `vrr_vcount`

## Requirements
- R1: All totals are programmed as the last line index (line count minus one). With no trigger, a frame ends on the strobe taken while `vcount` equals `vmax`. The count then reads 0, so the frame spans `vmax`+1 lines.
- R2: With `vrr_en`=1 and `trig_en`=1, a `trig_in` pulse taken while `vcount` >= `vmin` ends the frame. If a strobe arrives in the same cycle, `vcount` reads 0 after that edge. Otherwise the trigger is kept pending and the frame ends on the next strobe.
- R3: A trigger taken while `vcount` < `vmin` is ignored and is not kept for a later line. The frame runs to its total.
- R4: When `stop_timer` is non-zero, the first strobe at `vcount` = `stop_line` freezes the counter. `ext_valid` goes to 1 and `ext_count` starts at 0, then rises by 1 per strobe up to `stop_timer`-1. The next strobe releases the freeze: `vcount` becomes `stop_line`+1, `ext_valid` becomes 0 and `ext_count` becomes 0. The frame gains `stop_timer` lines.
- R5: An accepted trigger while `ext_valid` is 1 ends the frame on the next clock edge without waiting for a strobe. The same edge brings `vcount` to 0 and clears `ext_count` and `ext_valid`.
- R6: With `trig_en`=0, every trigger is ignored. A fixed long frame therefore always spans `vmax`+1+`stop_timer` lines.
- R7: With `vrr_en`=0, the trigger, the stop timer and the mid total have no effect, and every frame spans `vmax`+1 lines.
- R8: If a frame boundary captures `vrr_en`=1 with `mid_en`=1 after a frame in which the pair was not both 1, the next `mid_frames` frames end at `vmid`. Later frames end at `vmax`.
- R9: `frame_start` is 1 for exactly the cycle in which `vcount` has just returned to 0 at the end of a frame. It is 0 after reset.
- R10: Configuration inputs are captured only at a frame end and on the first clock after reset. A change made in the middle of a frame affects only the following frame.
- R11: During reset, `vcount`, `ext_count`, `ext_valid` and `frame_start` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_adv | input | 1 | Line strobe; one pulse per line |
| trig_in | input | 1 | Early frame-end request, one cycle |
| vrr_en | input | 1 | Variable refresh enable (minimum and maximum selection) |
| trig_en | input | 1 | Trigger acceptance enable |
| vmin | input | VW | Earliest line at which a trigger may end the frame |
| vmax | input | VW | Last line of a frame without a trigger |
| vmid | input | VW | Last line used while the mid override is active |
| stop_line | input | VW | Line at which the counter freezes for the extension |
| stop_timer | input | TW | Number of extra lines; 0 disables the freeze |
| mid_en | input | 1 | Mid override enable |
| mid_frames | input | FW | Number of frames that use the mid total |
| vcount | output | VW | Current line |
| ext_count | output | TW | Extension line counter |
| ext_valid | output | 1 | Counter is frozen and `ext_count` is counting |
| frame_start | output | 1 | One-cycle pulse on return to line 0 |

## Verification
Every output is a register. A strobe or an accepted trigger therefore shows on `vcount`, `ext_count`, `ext_valid` and `frame_start` after one clock edge. A trigger during the freeze also takes one edge, with no strobe needed. A configuration change shows only in the frame after the next `frame_start`. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each result is read exactly one edge after its cause. Frame lengths are measured by counting falling edges from one `frame_start` to the next. The bench drives the trigger only in the cycle where the line it has just read equals the target line.

// File: rtl/vrr_pkg.sv
package vrr_pkg;

   // progress of the freeze-and-extend step within one frame
   typedef enum logic [1:0] {
      HS_RUN  = 2'd0,   // stop line not yet passed in this frame
      HS_HOLD = 2'd1,   // counter frozen, extension counter running
      HS_DONE = 2'd2    // extension finished for this frame
   } hold_st_t;

endpackage

// File: rtl/vrr_cfg_shadow.sv
module vrr_cfg_shadow #(
   parameter int VW      = 11,
   parameter int TW      = 11,
   parameter int FW      = 4,
   parameter bit HAS_MID = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          wrap,
   input  logic          vrr_en,
   input  logic          trig_en,
   input  logic [VW-1:0] vmin,
   input  logic [VW-1:0] vmax,
   input  logic [VW-1:0] vmid,
   input  logic [VW-1:0] stop_line,
   input  logic [TW-1:0] stop_timer,
   input  logic          mid_en,
   input  logic [FW-1:0] mid_frames,
   output logic          vrr_s,
   output logic          trig_ok,
   output logic [VW-1:0] vmin_s,
   output logic [VW-1:0] end_line,
   output logic [VW-1:0] stop_s,
   output logic [TW-1:0] timer_s
);

   if (FW < 1) begin : g_chk_fw
      $error("vrr_cfg_shadow: FW must be at least 1");
   end

   logic          vrr_q;
   logic          ten_q;
   logic [VW-1:0] vmin_q;
   logic [VW-1:0] vmax_q;
   logic [VW-1:0] vmid_q;
   logic [VW-1:0] stop_q;
   logic [TW-1:0] timer_q;
   logic          use_mid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vrr_q   <= 1'b0;
         ten_q   <= 1'b0;
         vmin_q  <= '0;
         vmax_q  <= '0;
         vmid_q  <= '0;
         stop_q  <= '0;
         timer_q <= '0;
      end else if (load) begin
         vrr_q   <= vrr_en;
         ten_q   <= vrr_en & trig_en;
         vmin_q  <= vmin;
         vmax_q  <= vmax;
         vmid_q  <= vmid;
         stop_q  <= stop_line;
         timer_q <= vrr_en ? stop_timer : '0;
      end
   end

   if (HAS_MID) begin : g_mid
      logic          arm_q;
      logic [FW-1:0] left_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            arm_q  <= 1'b0;
            left_q <= '0;
         end else if (load) begin
            arm_q <= vrr_en & mid_en;
            if (vrr_en & mid_en) begin
               if (!arm_q)
                  left_q <= mid_frames;
               else if (wrap && left_q != '0)
                  left_q <= left_q - FW'(1);
            end else begin
               left_q <= '0;
            end
         end
      end

      assign use_mid = vrr_q && (left_q != '0);

      // R8: the override never runs longer than the frame count it was given
      a_r8_left_bounded: assert property (@(posedge clk) disable iff (!rst_n)
         (load && !arm_q && vrr_en && mid_en) |=> (left_q == $past(mid_frames)));
   end else begin : g_no_mid
      assign use_mid = 1'b0;
   end

   assign vrr_s    = vrr_q;
   assign trig_ok  = ten_q;
   assign vmin_s   = vmin_q;
   assign end_line = use_mid ? vmid_q : vmax_q;
   assign stop_s   = stop_q;
   assign timer_s  = timer_q;

   // R10: shadow values move only at a frame boundary
   a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(vmax_q) && $stable(vmin_q) && $stable(stop_q) && $stable(timer_q)));

   // R7: with refresh variation off, the extension timer is forced to zero
   a_r7_timer_off: assert property (@(posedge clk) disable iff (!rst_n)
      !vrr_q |-> (timer_q == '0 && !ten_q));

endmodule

// File: rtl/vrr_ext_timer.sv
module vrr_ext_timer
   import vrr_pkg::*;
#(
   parameter int VW = 11,
   parameter int TW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_adv,
   input  logic          wrap,
   input  logic [VW-1:0] vcount,
   input  logic [VW-1:0] stop_s,
   input  logic [TW-1:0] timer_s,
   output logic          holding,
   output logic          freeze,
   output logic          resume,
   output logic [TW-1:0] ext_count
);

   if (TW < 1) begin : g_chk_tw
      $error("vrr_ext_timer: TW must be at least 1");
   end

   hold_st_t      st_q;
   logic [TW-1:0] ext_q;
   logic          at_stop;
   logic          last;

   assign at_stop = (timer_s != '0) && (vcount == stop_s);
   assign last    = (ext_q == timer_s - TW'(1));
   assign holding = (st_q == HS_HOLD);
   assign freeze  = holding || (st_q == HS_RUN && at_stop);
   assign resume  = holding && line_adv && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= HS_RUN;
         ext_q <= '0;
      end else if (wrap) begin
         st_q  <= HS_RUN;
         ext_q <= '0;
      end else if (line_adv) begin
         case (st_q)
            HS_RUN: begin
               if (at_stop) begin
                  st_q  <= HS_HOLD;
                  ext_q <= '0;
               end
            end
            HS_HOLD: begin
               if (last) begin
                  st_q  <= HS_DONE;
                  ext_q <= '0;
               end else begin
                  ext_q <= ext_q + TW'(1);
               end
            end
            default: ;
         endcase
      end
   end

   assign ext_count = ext_q;

   // R4: extension counter stays below the programmed number of lines
   a_r4_ext_below_timer: assert property (@(posedge clk) disable iff (!rst_n)
      holding |-> (ext_q < timer_s));

   // R4: while frozen, the line counter sits on the stop line
   a_r4_frozen_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      holding |-> (vcount == stop_s));

   // R4: outside the freeze the extension counter reads zero
   a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !holding |-> (ext_q == '0));

endmodule

// File: rtl/vrr_line_ctr.sv
module vrr_line_ctr #(
   parameter int VW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_adv,
   input  logic          trig_in,
   input  logic          trig_ok,
   input  logic [VW-1:0] vmin_s,
   input  logic [VW-1:0] end_line,
   input  logic          freeze,
   input  logic          resume,
   input  logic          holding,
   output logic [VW-1:0] vcount,
   output logic          wrap,
   output logic          frame_start
);

   localparam logic [VW-1:0] LIMIT = {VW{1'b1}};

   logic [VW-1:0] cnt_q;
   logic          pend_q;
   logic          fs_q;
   logic          trig_hit;
   logic          step;
   logic          end_hold;
   logic          end_trig;
   logic          end_max;

   assign trig_hit = trig_in && trig_ok && (cnt_q >= vmin_s);
   assign step     = line_adv && (!freeze || resume);
   assign end_hold = holding && (trig_hit || pend_q);
   assign end_trig = line_adv && !holding && (trig_hit || pend_q);
   assign end_max  = step && (cnt_q == end_line || cnt_q == LIMIT);
   assign wrap     = end_hold || end_trig || end_max;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         fs_q   <= 1'b0;
      end else begin
         fs_q <= wrap;
         if (wrap) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
         end else begin
            if (step)
               cnt_q <= cnt_q + VW'(1);
            if (trig_hit)
               pend_q <= 1'b1;
         end
      end
   end

   assign vcount      = cnt_q;
   assign frame_start = fs_q;

   // R3: a kept trigger only exists once the earliest line is reached
   a_r3_pend_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (cnt_q >= vmin_s));

   // R2: a kept trigger ends the frame on the next strobe
   a_r2_pend_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && line_adv) |=> (cnt_q == '0));

endmodule

// File: rtl/vrr_vcount.sv
module vrr_vcount #(
   parameter int VW      = 11,
   parameter int TW      = 11,
   parameter int FW      = 4,
   parameter bit HAS_MID = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_adv,
   input  logic          trig_in,
   input  logic          vrr_en,
   input  logic          trig_en,
   input  logic [VW-1:0] vmin,
   input  logic [VW-1:0] vmax,
   input  logic [VW-1:0] vmid,
   input  logic [VW-1:0] stop_line,
   input  logic [TW-1:0] stop_timer,
   input  logic          mid_en,
   input  logic [FW-1:0] mid_frames,
   output logic [VW-1:0] vcount,
   output logic [TW-1:0] ext_count,
   output logic          ext_valid,
   output logic          frame_start
);

   if (VW < 2) begin : g_chk_vw
      $error("vrr_vcount: VW must be at least 2");
   end

   logic          first_q;
   logic          load;
   logic          wrap;
   logic          vrr_s;
   logic          trig_ok;
   logic [VW-1:0] vmin_s;
   logic [VW-1:0] end_line;
   logic [VW-1:0] stop_s;
   logic [TW-1:0] timer_s;
   logic          holding;
   logic          freeze;
   logic          resume;

   always_ff @(posedge clk) begin
      if (!rst_n) first_q <= 1'b1;
      else        first_q <= 1'b0;
   end

   assign load = first_q || wrap;

   vrr_cfg_shadow #(.VW(VW), .TW(TW), .FW(FW), .HAS_MID(HAS_MID)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .wrap       (wrap),
      .vrr_en     (vrr_en),
      .trig_en    (trig_en),
      .vmin       (vmin),
      .vmax       (vmax),
      .vmid       (vmid),
      .stop_line  (stop_line),
      .stop_timer (stop_timer),
      .mid_en     (mid_en),
      .mid_frames (mid_frames),
      .vrr_s      (vrr_s),
      .trig_ok    (trig_ok),
      .vmin_s     (vmin_s),
      .end_line   (end_line),
      .stop_s     (stop_s),
      .timer_s    (timer_s)
   );

   vrr_ext_timer #(.VW(VW), .TW(TW)) u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_adv  (line_adv),
      .wrap      (wrap),
      .vcount    (vcount),
      .stop_s    (stop_s),
      .timer_s   (timer_s),
      .holding   (holding),
      .freeze    (freeze),
      .resume    (resume),
      .ext_count (ext_count)
   );

   vrr_line_ctr #(.VW(VW)) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_adv    (line_adv),
      .trig_in     (trig_in),
      .trig_ok     (trig_ok),
      .vmin_s      (vmin_s),
      .end_line    (end_line),
      .freeze      (freeze),
      .resume      (resume),
      .holding     (holding),
      .vcount      (vcount),
      .wrap        (wrap),
      .frame_start (frame_start)
   );

   assign ext_valid = holding;

   // R9: the frame-start pulse coincides with line 0
   a_r9_fs_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (vcount == '0));

   // R5: an accepted trigger during the freeze restarts the frame at once
   a_r5_hold_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_valid && trig_in && trig_ok) |=> (vcount == '0 && !ext_valid && ext_count == '0));

   // R4: across two frozen cycles the line count does not move
   a_r4_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_valid && $past(ext_valid)) |-> $stable(vcount));

   // R7: no freeze ever happens with refresh variation off
   a_r7_no_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !vrr_s |-> !ext_valid);

endmodule

// File: tb/vrr_vcount_tb.sv
module vrr_vcount_tb;

   localparam int CLK_PERIOD = 10;
   localparam int VW = 11;
   localparam int TW = 11;
   localparam int FW = 4;
   localparam int NV = 15;

   typedef struct packed {
      logic        chain;
      logic        vrr;
      logic        ten;
      logic        men;
      logic [15:0] vmin;
      logic [15:0] vmax;
      logic [15:0] vmid;
      logic [15:0] stop;
      logic [15:0] timer;
      logic [15:0] midn;
      logic [15:0] trig_t;
      logic [15:0] exp_len;
   } vec_t;

   function automatic vec_t mk(input int c, input int v, input int t, input int m,
                               input int mn, input int mx, input int md, input int st,
                               input int tm, input int n, input int tt, input int ex);
      vec_t r;
      r.chain = c[0];  r.vrr = v[0];  r.ten = t[0];  r.men = m[0];
      r.vmin = 16'(mn); r.vmax = 16'(mx); r.vmid = 16'(md); r.stop = 16'(st);
      r.timer = 16'(tm); r.midn = 16'(n); r.trig_t = 16'(tt); r.exp_len = 16'(ex);
      return r;
   endfunction

   localparam int NT = 65535;

   // chain, vrr, trig_en, mid_en, vmin, vmax, vmid, stop, timer, mid_n, trigger line, frame length
   localparam vec_t VECS [NV] = '{
      mk(0,1,1,0,   9,  19,  0,    0,   0, 0,   NT,   20),  // R1 no trigger
      mk(0,1,1,0,   9,  19,  0,    0,   0, 0,   12,   13),  // R2 trigger inside window
      mk(0,1,1,0,   9,  19,  0,    0,   0, 0,    5,   20),  // R3 trigger before min
      mk(0,1,1,0,   9,  19,  0,    0,   0, 0,    9,   10),  // R2 trigger exactly at min
      mk(0,0,1,1,   3,  19,  7,    4,   5, 2,    5,   20),  // R7 variation off
      mk(0,1,1,0,   9,  19,  0,   10,   5, 0,   NT,   25),  // R4 short extension
      mk(0,1,1,0,   9,  19,  0,   10,   5, 0,   10,   11),  // R2 trigger on stop line
      mk(0,1,0,0,  19,  19,  0,   15,   7, 0,   12,   27),  // R6 fixed long frame
      mk(0,1,1,0, 999,1499,  0, 1000, 500, 0,   NT, 2000),  // R4 long extension
      mk(0,1,1,0, 999,1499,  0, 1000, 500, 0, 1200, 1701),  // R4 trigger after release
      mk(0,1,1,1,   9,  19, 14,    0,   0, 3,   NT,   15),  // R8 mid frame 1
      mk(1,1,1,1,   9,  19, 14,    0,   0, 3,   NT,   15),  // R8 mid frame 2
      mk(1,1,1,1,   9,  19, 14,    0,   0, 3,   NT,   15),  // R8 mid frame 3
      mk(1,1,1,1,   9,  19, 14,    0,   0, 3,   NT,   20),  // R8 back to max
      mk(0,1,1,0,   9,  19,  0,    0,   0, 0,   NT,   20)   // R8 override cleared
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_adv = 1'b0;
   logic          trig_in = 1'b0;
   logic          vrr_en = 1'b1;
   logic          trig_en = 1'b1;
   logic [VW-1:0] vmin = 11'd9;
   logic [VW-1:0] vmax = 11'd19;
   logic [VW-1:0] vmid = '0;
   logic [VW-1:0] stop_line = '0;
   logic [TW-1:0] stop_timer = '0;
   logic          mid_en = 1'b0;
   logic [FW-1:0] mid_frames = '0;
   logic [VW-1:0] vcount;
   logic [TW-1:0] ext_count;
   logic          ext_valid;
   logic          frame_start;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vrr_vcount #(.VW(VW), .TW(TW), .FW(FW), .HAS_MID(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .line_adv(line_adv), .trig_in(trig_in),
      .vrr_en(vrr_en), .trig_en(trig_en), .vmin(vmin), .vmax(vmax), .vmid(vmid),
      .stop_line(stop_line), .stop_timer(stop_timer), .mid_en(mid_en),
      .mid_frames(mid_frames), .vcount(vcount), .ext_count(ext_count),
      .ext_valid(ext_valid), .frame_start(frame_start)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      vrr_en     = v.vrr;
      trig_en    = v.ten;
      mid_en     = v.men;
      vmin       = v.vmin[VW-1:0];
      vmax       = v.vmax[VW-1:0];
      vmid       = v.vmid[VW-1:0];
      stop_line  = v.stop[VW-1:0];
      stop_timer = v.timer[TW-1:0];
      mid_frames = v.midn[FW-1:0];
   endtask

   task automatic wait_fs();
      do @(negedge clk); while (!frame_start);
   endtask

   // starts on a falling edge that shows frame_start; ends on the next one
   task automatic measure(input int t, output int len);
      len = 0;
      do begin
         trig_in = (t >= 0) && (int'(vcount) == t);
         len++;
         @(negedge clk);
      end while (!frame_start);
      trig_in = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         chk("watchdog", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int len;
      int prev_ext;
      bit prev_val;

      apply(VECS[0]);
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 vcount", int'(vcount), 0);
      chk("R11 ext_count", int'(ext_count), 0);
      chk("R11 ext_valid", int'(ext_valid), 0);
      chk("R11 frame_start", int'(frame_start), 0);
      rst_n    = 1'b1;
      line_adv = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         if (!VECS[i].chain) wait_fs();
         // R9 pulse sits on line 0
         chk("R9 line at start", int'(vcount), 0);
         measure((VECS[i].trig_t == 16'hFFFF) ? -1 : int'(VECS[i].trig_t), len);
         chk($sformatf("R1/R2/R3/R4/R6/R7/R8 vector %0d length", i), len, int'(VECS[i].exp_len));
      end

      // R9 pulse lasts one cycle
      @(negedge clk);
      chk("R9 single pulse", int'(frame_start), 0);
      wait_fs();

      // R10 change in the middle of a frame
      vmax = 11'd9;
      measure(-1, len);
      chk("R10 current frame keeps old total", len, 20);
      measure(-1, len);
      chk("R10 next frame uses new total", len, 10);

      // R2 kept trigger ends frame on next strobe
      vmax = 11'd19;
      wait_fs();
      while (vcount != 11'd12) @(negedge clk);
      line_adv = 1'b0;
      trig_in  = 1'b1;
      @(negedge clk);
      trig_in = 1'b0;
      repeat (3) @(negedge clk);
      chk("R2 no strobe keeps line", int'(vcount), 12);
      line_adv = 1'b1;
      @(negedge clk);
      chk("R2 pending trigger ends frame", int'(vcount), 0);
      chk("R2 frame_start on pending end", int'(frame_start), 1);

      // R5 trigger during freeze
      stop_line  = 11'd10;
      stop_timer = 11'd5;
      wait_fs();
      while (!ext_valid) @(negedge clk);
      chk("R4 extension starts at zero", int'(ext_count), 0);
      chk("R4 frozen on stop line", int'(vcount), 10);
      line_adv = 1'b0;
      trig_in  = 1'b1;
      @(negedge clk);
      trig_in = 1'b0;
      chk("R5 immediate restart", int'(vcount), 0);
      chk("R5 frame_start", int'(frame_start), 1);
      chk("R5 ext_valid cleared", int'(ext_valid), 0);

      // R4 release after the last extension line
      line_adv = 1'b1;
      prev_val = 1'b0;
      prev_ext = 0;
      @(negedge clk);
      while (!(prev_val && !ext_valid)) begin
         prev_val = ext_valid;
         prev_ext = int'(ext_count);
         @(negedge clk);
      end
      chk("R4 last extension value", prev_ext, 4);
      chk("R4 resumes after stop line", int'(vcount), 11);
      chk("R4 extension cleared", int'(ext_count), 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule